// File: doc/BRIEF.md
# Row Write Latch Buffer

This block gathers programming data for nonvolatile memory into a full row of data latches and then commits that row in one write. A command receiver hands it load strobes, each with a word address and a data value; the block keeps the value in the latch slot picked by the low address bits. Program-space loads keep a 16-bit word, and EEPROM-space loads keep one byte.

A separate begin-programming strobe starts the commit. The block then offers every slot of the row, in slot order, on a valid/ready memory write port. Each beat carries the full word address, formed from the row base and the slot index. Slots that were never loaded hold all ones. Erased memory reads as ones and a write can only clear bits, so those slots leave their cells unchanged.

When the final beat is accepted, the block sets every latch back to all ones and gives a one-cycle done pulse. A load that arrives while a row is still streaming is refused and reported with an error pulse. Erasing the row, verifying it and the flash timing itself are handled outside this block.

Top module: `row_latch_buf`

## Requirements
- R1: While reset is held and just after it, `wr_valid`, `wr_last`, `done` and `load_err` are 0, and every latch slot holds all ones.
- R2: A word load (`ld_valid`=1, `ld_byte`=0) while idle stores `ld_data` into slot `ld_addr[5:0]`.
- R3: A byte load (`ld_byte`=1) while idle stores `{8'hFF, ld_data[7:0]}` into slot `ld_addr[5:0]`. The upper 8 bits of `ld_data` are ignored.
- R4: A slot not loaded since the last commit or reset is streamed as 16'hFFFF.
- R5: `prog_start` while idle captures `prog_addr[21:6]` as the row base. From the next cycle the block streams slots 0 to 63 in order. Each beat has `wr_addr = {base, slot}`, and `wr_last`=1 only on slot 63.
- R6: While `wr_valid`=1 and `wr_ready`=0, the next cycle keeps `wr_valid`=1 with the same `wr_addr`, `wr_data` and `wr_last`.
- R7: In the cycle after the slot-63 beat is accepted, `done`=1 for exactly one cycle and `wr_valid`=0. All slots read back as all ones afterwards.
- R8: A load while a row is streaming gives `load_err`=1 in the next cycle for one cycle, and the latches are left unchanged.
- R9: `prog_start` while a row is streaming has no effect on the beats, base or order.
- R10: A later load to a slot that was already loaded replaces the earlier value.
- R11: When a load and `prog_start` arrive in the same idle cycle, the load is stored and appears in the row that this strobe starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load strobe |
| ld_byte | input | 1 | 1 = EEPROM byte load, 0 = 16-bit word load |
| ld_addr | input | 22 | Word address of the load |
| ld_data | input | 16 | Load data |
| prog_start | input | 1 | Begin-programming strobe |
| prog_addr | input | 22 | Address whose upper bits give the row base |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | 22 | Word address of the beat |
| wr_data | output | 16 | Data of the beat |
| wr_last | output | 1 | Final beat of the row |
| done | output | 1 | One-cycle pulse after the row commit ends |
| load_err | output | 1 | One-cycle pulse when a load is refused |

## Verification
Loads are stored on the clock edge where they are sampled, so their effect first shows in a streamed beat. The first beat appears in the cycle after the edge that samples `prog_start`. Each following beat appears in the cycle after the previous beat is accepted. `done` and `load_err` appear in the cycle right after the edge that causes them.

The bench drives its inputs on the falling edge and keeps a behavioural row model that it advances on each rising edge. It compares every output on the next falling edge, so each expected value is sampled exactly one register stage after its cause. Ready patterns with stalls, loads and strobes during streaming, and a fully unloaded row check the hold, refusal and all-ones defaults.

// File: rtl/rwl_pkg.sv
package rwl_pkg;

  typedef enum logic {
    RWL_IDLE   = 1'b0,
    RWL_STREAM = 1'b1
  } rwl_state_e;

  // Form the latch word for a load: byte loads keep the upper byte erased.
  function automatic logic [15:0] rwl_pack_word(input logic is_byte,
                                                input logic [15:0] raw);
    return is_byte ? {8'hFF, raw[7:0]} : raw;
  endfunction

endpackage

// File: rtl/rwl_rst_sync.sv
module rwl_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  // Assert asynchronously, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/rwl_latch_bank.sv
module rwl_latch_bank #(
  parameter int ROW_WORDS = 64,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = $clog2(ROW_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              clr_all,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] slot_q [ROW_WORDS];

  for (genvar g = 0; g < ROW_WORDS; g++) begin : g_slot
    logic              slot_en;
    logic [DATA_W-1:0] slot_d;

    always_comb begin
      slot_en = clr_all || (wr_en && (wr_idx == IDX_W'(g)));
      slot_d  = clr_all ? {DATA_W{1'b1}} : wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[g] <= {DATA_W{1'b1}};
      else if (slot_en) slot_q[g] <= slot_d;
    end
  end

  assign rd_word = slot_q[rd_idx];

  // A load and a clear never arrive in the same cycle.
  AST_NO_LOAD_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |-> !wr_en); // R8
endmodule

// File: rtl/rwl_seq.sv
module rwl_seq
  import rwl_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int ROW_WORDS = 64,
  localparam int IDX_W    = $clog2(ROW_WORDS),
  localparam int BASE_W   = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic              prog_start,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic              wr_ready,
  output logic              ld_accept,
  output logic              clr_all,
  output logic [IDX_W-1:0]  idx,
  output logic [BASE_W-1:0] base,
  output logic              wr_valid,
  output logic              wr_last,
  output logic              done,
  output logic              load_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROW_WORDS - 1);

  rwl_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              base_en, idx_en;
  logic              beat_fire;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    base_d    = prog_addr[ADDR_W-1:IDX_W];
    base_en   = 1'b0;
    idx_en    = 1'b0;
    done_d    = 1'b0;
    err_d     = 1'b0;
    clr_all   = 1'b0;
    ld_accept = 1'b0;
    beat_fire = (st_q == RWL_STREAM) && wr_ready;
    unique case (st_q)
      RWL_IDLE: begin
        ld_accept = ld_valid;
        if (prog_start) begin
          st_d    = RWL_STREAM;
          base_en = 1'b1;
          idx_en  = 1'b1;
          idx_d   = '0;
        end
      end
      RWL_STREAM: begin
        err_d = ld_valid;
        if (beat_fire) begin
          if (idx_q == LAST_IDX) begin
            st_d    = RWL_IDLE;
            clr_all = 1'b1;
            done_d  = 1'b1;
          end else begin
            idx_en = 1'b1;
            idx_d  = idx_q + 1'b1;
          end
        end
      end
      default: st_d = RWL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RWL_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  assign idx      = idx_q;
  assign base     = base_q;
  assign wr_valid = (st_q == RWL_STREAM);
  assign wr_last  = wr_valid && (idx_q == LAST_IDX);
  assign done     = done_q;
  assign load_err = err_q;

  AST_ERR_ON_BUSY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ld_valid) |=> load_err); // R8
  AST_NO_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid) |=> !load_err); // R8
  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !(wr_ready && wr_last)) |=> $stable(base)); // R9
endmodule

// File: rtl/row_latch_buf.sv
module row_latch_buf
  import rwl_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int ROW_WORDS = 64,
  localparam int IDX_W    = $clog2(ROW_WORDS),
  localparam int BASE_W   = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic              ld_byte,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              prog_start,
  input  logic [ADDR_W-1:0] prog_addr,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_last,
  output logic              done,
  output logic              load_err
);
  logic              rst_n_s;
  logic              ld_accept, clr_all;
  logic [IDX_W-1:0]  rd_idx;
  logic [BASE_W-1:0] base;
  logic [DATA_W-1:0] ld_word;

  rwl_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  assign ld_word = rwl_pack_word(ld_byte, ld_data);

  rwl_seq #(.ADDR_W(ADDR_W), .ROW_WORDS(ROW_WORDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ld_valid   (ld_valid),
    .prog_start (prog_start),
    .prog_addr  (prog_addr),
    .wr_ready   (wr_ready),
    .ld_accept  (ld_accept),
    .clr_all    (clr_all),
    .idx        (rd_idx),
    .base       (base),
    .wr_valid   (wr_valid),
    .wr_last    (wr_last),
    .done       (done),
    .load_err   (load_err)
  );

  rwl_latch_bank #(.ROW_WORDS(ROW_WORDS), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (ld_accept),
    .wr_idx  (ld_addr[IDX_W-1:0]),
    .wr_word (ld_word),
    .clr_all (clr_all),
    .rd_idx  (rd_idx),
    .rd_word (wr_data)
  );

  assign wr_addr = {base, rd_idx};

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_last))); // R6
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_valid && wr_ready && !wr_last) |=> (wr_valid && wr_addr[IDX_W-1:0] == $past(wr_addr[IDX_W-1:0]) + 1'b1)); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_valid && wr_ready && wr_last) |=> (done && !wr_valid)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done); // R7
  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(wr_valid) |-> (wr_addr[IDX_W-1:0] == '0)); // R5
endmodule

// File: tb/row_latch_buf_tb_top.sv
module row_latch_buf_tb_top;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int RW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_valid, ld_byte, prog_start, wr_ready;
  logic [AW-1:0] ld_addr, prog_addr;
  logic [DW-1:0] ld_data;
  logic          wr_valid, wr_last, done, load_err;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  int ready_mode = 0;

  // Behavioural reference model
  int          m_row [RW];
  bit          m_busy;
  int          m_idx;
  int          m_base;
  bit          m_done, m_err;

  row_latch_buf dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_byte(ld_byte),
    .ld_addr(ld_addr), .ld_data(ld_data), .prog_start(prog_start),
    .prog_addr(prog_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last),
    .done(done), .load_err(load_err)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    m_done = 0;
    m_err  = 0;
    if (!rst_n) begin
      for (int i = 0; i < RW; i++) m_row[i] = 'hFFFF;
      m_busy = 0; m_idx = 0; m_base = 0;
    end else if (m_busy) begin
      if (ld_valid) m_err = 1;
      if (wr_ready) begin
        if (m_idx == RW - 1) begin
          m_busy = 0; m_done = 1;
          for (int i = 0; i < RW; i++) m_row[i] = 'hFFFF;
        end else m_idx++;
      end
    end else begin
      if (ld_valid)
        m_row[ld_addr[5:0]] = ld_byte ? ('hFF00 | ld_data[7:0]) : int'(ld_data);
      if (prog_start) begin
        m_busy = 1; m_idx = 0; m_base = int'(prog_addr[AW-1:6]);
      end
    end
  end

  // Compare every output one half-cycle after each edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5/R9 wr_valid", wr_valid, m_busy);
      chk("R7 done", done, m_done);
      chk("R8 load_err", load_err, m_err);
      if (m_busy) begin
        chk("R5 wr_addr", wr_addr, (longint'(m_base) << 6) | m_idx);
        chk("R2/R3/R4/R10/R11 wr_data", wr_data, m_row[m_idx]);
        chk("R5 wr_last", wr_last, m_idx == RW - 1);
      end else chk("R1 wr_last idle", wr_last, 0);
    end
    case (ready_mode)
      0: wr_ready <= 1'b1;
      1: wr_ready <= (cyc % 3) != 1;
      default: wr_ready <= (cyc % 5) == 0;
    endcase
  end

  task automatic idle_inputs();
    ld_valid = 0; ld_byte = 0; ld_addr = '0; ld_data = '0;
    prog_start = 0; prog_addr = '0;
  endtask

  task automatic load(input bit byt, input int addr, input int data);
    @(negedge clk);
    ld_valid = 1; ld_byte = byt; ld_addr = AW'(addr); ld_data = DW'(data);
    @(negedge clk);
    ld_valid = 0; ld_byte = 0;
  endtask

  task automatic start(input int addr);
    @(negedge clk);
    prog_start = 1; prog_addr = AW'(addr);
    @(negedge clk);
    prog_start = 0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic stimulus();
    idle_inputs();
    wr_ready = 1;
    rst_n = 0;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 load_err", load_err, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // Row A: R1/R4 unloaded slots stream all ones
    ready_mode = 0;
    start('h12_3456);
    wait_idle();

    // Row B: word/byte loads, overwrite, high slot
    load(0, 'h000040, 'h1234);          // R2 slot 0
    load(0, 'h00007F, 'hBEEF);          // R2 slot 63
    load(1, 'h000005, 'hA55A);          // R3 byte, upper ignored
    load(0, 'h000009, 'h0F0F);
    load(0, 'h000049, 'h7777);          // R10 overwrite slot 9
    ready_mode = 1;
    start('h3F_FFC0);
    // R8/R9: loads and a restart while streaming
    load(0, 'h000003, 'h0000);
    start('h00_0000);
    load(1, 'h000004, 'h0011);
    wait_idle();

    // Row C: after commit, latches are all ones again (R7/R4)
    ready_mode = 2;
    load(1, 'h000020, 'h3C3C);
    // R11: load and start in the same cycle
    @(negedge clk);
    ld_valid = 1; ld_addr = AW'('h00_0021); ld_data = 'h4242;
    prog_start = 1; prog_addr = AW'('h15_5540);
    @(negedge clk);
    idle_inputs();
    wait_idle();

    ready_mode = 0;
    start('h00_0080);
    wait_idle();
  endtask

  initial begin
    fork
      stimulus();
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule